// File: doc/BRIEF.md
# Rider-Balanced Steering Enable

This block decides when the steering input of a self-balancing platform may be honoured. It watches the left and right load-cell weights, which an external converter delivers together with a one-cycle strobe. From each accepted pair it forms the total weight and the magnitude of the left/right imbalance. It then tracks whether a rider is standing on the platform and whether that rider is standing evenly.

Steering is granted only after the rider has remained evenly balanced, without a break, for a fixed dwell. The dwell is about 1.34 s at 50 MHz, which is 2^26 clocks. A simulation option cuts it to 2^FAST_TMR_W clocks. Weight thresholds and imbalance limits carry hysteresis, so a reading that sits near a limit does not toggle the outputs. A separate registered flag reports that the platform is unloaded. Both outputs are held inactive whenever the platform is not powered up.

Top module: `steer_gate`

## Requirements
- R1: While rst_n is low and right after reset, en_steer is 0 and rider_off is 1.
- R2: rider_off changes two clock edges after a strobed sample. It is 1 when left+right < MIN_RIDER-HYST (448 by default) and 0 otherwise.
- R3: An unloaded platform counts as carrying a rider only once the sum exceeds MIN_RIDER (512 by default). A sum between 448 and 512 keeps whatever presence decision was already made, so it neither starts a dwell nor ends steering.
- R4: With pwr_up high, a rider present and every sample balanced (4*|left-right| < sum), en_steer rises 2^FAST_TMR_W clocks after the dwell starts (FAST_SIM=1), or 2^SLOW_TMR_W clocks after it starts (FAST_SIM=0).
- R5: en_steer does not rise before the full dwell has elapsed.
- R6: An unbalanced sample during the dwell clears the dwell count. A later balanced sample starts a complete new dwell.
- R7: While steering, an imbalance with 4*|d| >= sum and 16*|d| <= 15*sum keeps en_steer high. An imbalance with 16*|d| > 15*sum drops en_steer within three edges of the strobe, and a full dwell is then needed again.
- R8: A sum below 448 drops en_steer from any state, and a returning rider needs a complete dwell.
- R9: en_steer is 0 whenever pwr_up is 0. When pwr_up returns, a complete dwell is needed again.
- R10: Load-cell inputs are sampled only in cycles where smp_vld is 1. Changes without the strobe affect no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wt_left | input | WT_W | Left load-cell weight |
| wt_right | input | WT_W | Right load-cell weight |
| smp_vld | input | 1 | One-cycle strobe, weight pair valid |
| pwr_up | input | 1 | Platform powered and authorised |
| en_steer | output | 1 | Steering permitted |
| rider_off | output | 1 | Registered flag, platform unloaded |

## Verification
The bench first targets the weight band between the two presence thresholds. A design without hysteresis would start a dwell from an unloaded platform inside that band, or drop steering when a steering rider's weight settles into it. The bench probes both ends of the dwell and an interrupted dwell. A timer that is off by a large margin, or one that keeps its count across an unbalanced sample, grants steering at the wrong point. The bench then separates moderate imbalance, which must be tolerated while steering, from severe imbalance, which must cut steering at once. It finally checks that a power loss, a departing rider or weight changes without the strobe leave the outputs as required.

// File: rtl/steer_gate_pkg.sv
package steer_gate_pkg;

   // Sequencer states of the steering grant
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_STEER = 2'd2
   } sg_state_e;

   // Registered classification of the latest accepted sample
   typedef struct packed {
      logic present;   // rider on platform (with hysteresis)
      logic off;       // sum below rider-off threshold
      logic bal;       // imbalance small enough to count the dwell
      logic severe;    // imbalance large enough to cut steering
   } sg_cls_t;

   localparam sg_cls_t CLS_RESET = '{present: 1'b0, off: 1'b1, bal: 1'b0, severe: 1'b0};

endpackage

// File: rtl/sg_weigh.sv
module sg_weigh
   import steer_gate_pkg::*;
#(
   parameter int WT_W       = 12,
   parameter int MIN_RIDER  = 512,
   parameter int HYST       = 64,
   parameter int BAL_SHIFT  = 2,
   parameter int DROP_NUM   = 15,
   parameter int DROP_SHIFT = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [WT_W-1:0] wt_l,
   input  logic [WT_W-1:0] wt_r,
   input  logic            smp_vld,
   output sg_cls_t         cls
);

   localparam int SUM_W = WT_W + 1;
   localparam int CMP_W = SUM_W + DROP_SHIFT;
   localparam int OFF_LIM = MIN_RIDER - HYST;

   logic [WT_W-1:0]  lat_l, lat_r;
   logic [SUM_W-1:0] sum_c;
   logic [WT_W-1:0]  ad_c;
   logic [CMP_W-1:0] bal_lhs, drop_lhs, drop_rhs, sum_x;
   logic             on_c, gone_c, bal_c, sev_c;

   // Sample latch: only strobed pairs are taken in
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_l <= '0;
         lat_r <= '0;
      end else if (smp_vld) begin
         lat_l <= wt_l;
         lat_r <= wt_r;
      end
   end

   // Sum and absolute difference
   always_comb begin
      sum_c = {1'b0, lat_l} + {1'b0, lat_r};
      ad_c  = (lat_l >= lat_r) ? (lat_l - lat_r) : (lat_r - lat_l);
      sum_x = CMP_W'(sum_c);
      bal_lhs  = CMP_W'(ad_c) << BAL_SHIFT;
      drop_lhs = CMP_W'(ad_c) << DROP_SHIFT;
   end

   // Severe-imbalance limit: shift-and-subtract when the fraction is (2^k-1)/2^k
   generate
      if (DROP_NUM == (1 << DROP_SHIFT) - 1) begin : g_drop_sub
         assign drop_rhs = (sum_x << DROP_SHIFT) - sum_x;
      end else begin : g_drop_mul
         assign drop_rhs = sum_x * CMP_W'(DROP_NUM);
      end
   endgenerate

   always_comb begin
      on_c   = sum_c > SUM_W'(MIN_RIDER);
      gone_c = sum_c < SUM_W'(OFF_LIM);
      bal_c  = bal_lhs < sum_x;
      sev_c  = drop_lhs > drop_rhs;
   end

   // Classification register with presence hysteresis
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cls <= CLS_RESET;
      end else begin
         if (gone_c)
            cls.present <= 1'b0;
         else if (on_c)
            cls.present <= 1'b1;
         cls.off    <= gone_c;
         cls.bal    <= bal_c;
         cls.severe <= sev_c;
      end
   end

   // R2
   off_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cls.off |-> !cls.present);

   // R3
   rise_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cls.present) |-> ($past(sum_c) > SUM_W'(MIN_RIDER)));

   // R7
   sev_bal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cls.severe |-> !cls.bal);

endmodule

// File: rtl/sg_dwell.sv
module sg_dwell #(
   parameter int FAST_SIM   = 1,
   parameter int SLOW_TMR_W = 26,
   parameter int FAST_TMR_W = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cnt_en,
   output logic done
);

   logic [SLOW_TMR_W-1:0] cnt;

   // Counts while enabled, any break returns it to zero
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (cnt_en)
         cnt <= cnt + 1'b1;
      else
         cnt <= '0;
   end

   // Carry-out of the full counter, or of its low bits for fast runs
   generate
      if (FAST_SIM != 0) begin : g_fast
         assign done = cnt_en & (&cnt[FAST_TMR_W-1:0]);
      end else begin : g_slow
         assign done = cnt_en & (&cnt);
      end
   endgenerate

   // R6
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> (cnt == SLOW_TMR_W'($past(cnt) + 1'b1)));

endmodule

// File: rtl/sg_ctl.sv
module sg_ctl
   import steer_gate_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pwr_up,
   input  sg_cls_t   cls,
   input  logic      tmr_done,
   output sg_state_e state,
   output logic      cnt_en
);

   sg_state_e nxt;

   assign cnt_en = pwr_up & cls.present & cls.bal & (state == ST_WAIT);

   always_comb begin
      nxt = state;
      if (!pwr_up || !cls.present) begin
         nxt = ST_IDLE;
      end else begin
         unique case (state)
            ST_IDLE:  nxt = ST_WAIT;
            ST_WAIT:  if (tmr_done) nxt = ST_STEER;
            ST_STEER: if (cls.severe) nxt = ST_WAIT;
            default:  nxt = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= ST_IDLE;
      else
         state <= nxt;
   end

   // R5
   entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STEER && $past(state) != ST_STEER) |-> $past(tmr_done));

   // R8
   gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cls.present |=> (state == ST_IDLE));

   // R7
   drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STEER && cls.severe) |=> (state != ST_STEER));

   // R9
   pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_up |=> (state == ST_IDLE));

endmodule

// File: rtl/steer_gate.sv
module steer_gate
   import steer_gate_pkg::*;
#(
   parameter int FAST_SIM   = 1,
   parameter int SLOW_TMR_W = 26,
   parameter int FAST_TMR_W = 15,
   parameter int WT_W       = 12,
   parameter int MIN_RIDER  = 512,
   parameter int HYST       = 64,
   parameter int BAL_SHIFT  = 2,
   parameter int DROP_NUM   = 15,
   parameter int DROP_SHIFT = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [WT_W-1:0] wt_left,
   input  logic [WT_W-1:0] wt_right,
   input  logic            smp_vld,
   input  logic            pwr_up,
   output logic            en_steer,
   output logic            rider_off
);

   // Elaboration-time parameter checks
   generate
      if (HYST <= 0 || HYST >= MIN_RIDER) begin : g_bad_hyst
         $error("HYST must lie between 1 and MIN_RIDER-1");
      end
      if (MIN_RIDER >= (1 << (WT_W + 1))) begin : g_bad_min
         $error("MIN_RIDER exceeds the sum range");
      end
      if (BAL_SHIFT < 1 || BAL_SHIFT > DROP_SHIFT) begin : g_bad_bal
         $error("BAL_SHIFT must be between 1 and DROP_SHIFT");
      end
      if (DROP_NUM < 1 || DROP_NUM >= (1 << DROP_SHIFT)) begin : g_bad_drop
         $error("DROP_NUM must be a proper fraction of 2^DROP_SHIFT");
      end
      if (FAST_TMR_W < 2 || FAST_TMR_W > SLOW_TMR_W) begin : g_bad_tmr
         $error("FAST_TMR_W must be between 2 and SLOW_TMR_W");
      end
   endgenerate

   sg_cls_t   cls;
   sg_state_e state;
   logic      cnt_en, tmr_done;

   sg_weigh #(
      .WT_W(WT_W), .MIN_RIDER(MIN_RIDER), .HYST(HYST),
      .BAL_SHIFT(BAL_SHIFT), .DROP_NUM(DROP_NUM), .DROP_SHIFT(DROP_SHIFT)
   ) u_weigh (
      .clk(clk), .rst_n(rst_n), .wt_l(wt_left), .wt_r(wt_right),
      .smp_vld(smp_vld), .cls(cls)
   );

   sg_dwell #(
      .FAST_SIM(FAST_SIM), .SLOW_TMR_W(SLOW_TMR_W), .FAST_TMR_W(FAST_TMR_W)
   ) u_dwell (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .done(tmr_done)
   );

   sg_ctl u_ctl (
      .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .cls(cls),
      .tmr_done(tmr_done), .state(state), .cnt_en(cnt_en)
   );

   assign en_steer  = pwr_up & (state == ST_STEER);
   assign rider_off = cls.off;

   // R9
   en_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_steer) |-> $past(cnt_en));

endmodule

// File: tb/steer_gate_test.sv
module steer_gate_test;

   localparam int TW = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] wl = '0, wr = '0;
   logic        smp_vld = 1'b0;
   logic        pwr_up = 1'b0;
   logic        en_steer, rider_off;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   steer_gate #(.FAST_TMR_W(TW)) uut (
      .clk(clk), .rst_n(rst_n), .wt_left(wl), .wt_right(wr),
      .smp_vld(smp_vld), .pwr_up(pwr_up),
      .en_steer(en_steer), .rider_off(rider_off)
   );

   // {left, right, expected rider_off}, applied with pwr_up low
   localparam logic [24:0] VEC [8] = '{
      {12'd0,    12'd0,    1'b1},
      {12'd300,  12'd300,  1'b0},
      {12'd224,  12'd223,  1'b1},
      {12'd224,  12'd224,  1'b0},
      {12'd100,  12'd400,  1'b0},
      {12'd4095, 12'd4095, 1'b0},
      {12'd0,    12'd447,  1'b1},
      {12'd2000, 12'd0,    1'b0}
   };

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0b exp=%0b", req, act, exp);
      end
   endtask

   task automatic apply(input int l, input int r);
      @(negedge clk);
      wl = 12'(l);
      wr = 12'(r);
      smp_vld = 1'b1;
      @(negedge clk);
      smp_vld = 1'b0;
   endtask

   task automatic pause(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      pause(3);
      chk("R1 en_steer in reset", en_steer, 1'b0);
      chk("R1 rider_off in reset", rider_off, 1'b1);
      rst_n = 1'b1;
      pause(2);
      chk("R1 en_steer after reset", en_steer, 1'b0);
      chk("R1 rider_off after reset", rider_off, 1'b1);

      // R2 table walk, power off (R9)
      for (int i = 0; i < 8; i++) begin
         apply(int'(VEC[i][24:13]), int'(VEC[i][12:1]));
         pause(2);
         chk("R2 rider_off threshold", rider_off, VEC[i][0]);
         chk("R9 no steer without power", en_steer, 1'b0);
      end

      pwr_up = 1'b1;
      apply(0, 0);
      pause(4);

      // R3 inside hysteresis band from unloaded: no dwell
      apply(240, 240);
      pause(1100);
      chk("R3 band does not start dwell", en_steer, 1'b0);
      chk("R2 band not off", rider_off, 1'b0);

      // R4 / R5 full dwell
      apply(300, 300);
      pause(1000);
      chk("R5 not before dwell", en_steer, 1'b0);
      pause(40);
      chk("R4 steer after dwell", en_steer, 1'b1);

      // R3 band keeps a present rider
      apply(240, 240);
      pause(20);
      chk("R3 band holds steering", en_steer, 1'b1);

      // R7 moderate imbalance tolerated
      apply(400, 200);
      pause(20);
      chk("R7 moderate imbalance kept", en_steer, 1'b1);

      // R7 severe imbalance drops, full dwell again
      apply(600, 10);
      pause(4);
      chk("R7 severe drop", en_steer, 1'b0);
      apply(300, 300);
      pause(500);
      chk("R7 dwell after drop early", en_steer, 1'b0);
      pause(600);
      chk("R7 dwell after drop done", en_steer, 1'b1);

      // R6 interrupted dwell restarts
      apply(600, 10);
      apply(300, 300);
      pause(600);
      apply(400, 200);
      pause(10);
      apply(300, 300);
      pause(1000);
      chk("R6 restart not early", en_steer, 1'b0);
      pause(40);
      chk("R6 restart completes", en_steer, 1'b1);

      // R10 unstrobed inputs ignored
      @(negedge clk);
      wl = 12'd0;
      wr = 12'd0;
      pause(20);
      chk("R10 rider_off unchanged", rider_off, 1'b0);
      chk("R10 en_steer unchanged", en_steer, 1'b1);

      // R9 power loss
      @(negedge clk);
      pwr_up = 1'b0;
      @(negedge clk);
      chk("R9 power loss drops", en_steer, 1'b0);
      pwr_up = 1'b1;
      pause(500);
      chk("R9 dwell after power early", en_steer, 1'b0);
      pause(600);
      chk("R9 dwell after power done", en_steer, 1'b1);

      // R8 rider leaves and returns
      apply(100, 100);
      pause(4);
      chk("R8 rider gone drops", en_steer, 1'b0);
      chk("R8 rider_off set", rider_off, 1'b1);
      apply(300, 300);
      pause(1000);
      chk("R8 return not early", en_steer, 1'b0);
      pause(40);
      chk("R8 return completes", en_steer, 1'b1);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule